// File: doc/BRIEF.md
# Reduced Five-State Serial Bit Responder

This block is a Mealy finite-state machine that watches a serial stream of single bits and raises a one-bit response whenever a 1 arrives while the machine sits in either of its two "armed" states. It has five states, named A to E. It is the minimised form of a seven-state behaviour: two pairs of equivalent states were merged, and the result answers every input sequence exactly as the larger machine would.

Bits enter through a valid/ready port. The block is always able to take a bit, so `bit_ready` is held high and the sender never sees back-pressure. A bit is consumed on every rising clock edge where `bit_valid` is high. The response is Mealy-style: it is formed in the same cycle from the current state and the offered bit, and it is presented with `resp_valid` equal to `bit_valid`. The response side has no ready input, because the block stores no responses and the downstream side must take each one in the cycle it is offered. The current state code is brought out for observation. A synchronous active-high reset returns the machine to state A.

Top module: `resp_fsm`

## Requirements
- R1: When `rst` is high at a rising edge, the state code becomes 000 (state A) after that edge. During reset `resp_bit` is 0 and no bit is consumed.
- R2: In state A (code 000) a consumed 0 keeps the machine in A and a consumed 1 moves it to B (code 001). The response is 0 for both inputs.
- R3: In state B (code 001) a consumed 0 moves to C (code 010) and a consumed 1 moves to D (code 011). The response is 0 for both inputs.
- R4: In state C (code 010) a consumed 0 moves to A and a consumed 1 moves to D. The response is 0 for both inputs.
- R5: In state D (code 011) a consumed 0 moves to E (code 100) with response 0. A consumed 1 keeps the machine in D with response 1.
- R6: In state E (code 100) a consumed 0 moves to A with response 0. A consumed 1 moves to D with response 1.
- R7: While `bit_valid` is low the state code does not change, `resp_valid` is 0 and `resp_bit` is 0.
- R8: `bit_ready` is always 1, and `resp_valid` equals `bit_valid` in the same cycle.
- R9: Starting from A, the bits 0,1,0,1,0,1,1,0,1,0,0 pass through the states A,B,C,D,E,D,D,E,D,E and end in A. They produce the responses 0,0,0,0,0,1,1,0,1,0,0.
- R10: The state code is always one of 000 to 100. Any other code is sent back to 000 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state A |
| bit_valid | input | 1 | Offered serial bit is valid |
| bit_ready | output | 1 | Always high; the block accepts a bit every cycle |
| bit_in | input | 1 | Serial data bit |
| resp_valid | output | 1 | Response valid, equal to bit_valid |
| resp_bit | output | 1 | Mealy response for the offered bit |
| state_code | output | 3 | Current state: A=000, B=001, C=010, D=011, E=100 |

## Verification
The response and its valid flag depend on the bit offered in the current cycle, so they are due in the same cycle, with no register in the path. The state code changes only at the first rising edge after a bit is consumed. The bench drives each bit just after a falling edge and compares `resp_valid`, `resp_bit` and `state_code` with a table-driven model a moment later, before the next rising edge. It then advances the model at that rising edge. This way every response is compared against the state that was in force when its bit was offered.

// File: rtl/resp_fsm_pkg.sv
package resp_fsm_pkg;
  localparam int unsigned NUM_STATES = 5;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_A = 3'd0,
    ST_B = 3'd1,
    ST_C = 3'd2,
    ST_D = 3'd3,
    ST_E = 3'd4
  } rstate_t;
endpackage

// File: rtl/resp_fsm_next.sv
module resp_fsm_next
  import resp_fsm_pkg::*;
(
  input  rstate_t cur,
  input  logic    adv,
  input  logic    bit_in,
  output rstate_t nxt
);
  rstate_t stepped;

  always_comb begin
    case (cur)
      ST_A:    stepped = bit_in ? ST_B : ST_A;
      ST_B:    stepped = bit_in ? ST_D : ST_C;
      ST_C:    stepped = bit_in ? ST_D : ST_A;
      ST_D:    stepped = bit_in ? ST_D : ST_E;
      ST_E:    stepped = bit_in ? ST_D : ST_A;
      default: stepped = ST_A;
    endcase
  end

  always_comb begin
    if (adv) nxt = stepped;
    else if (cur > ST_E) nxt = ST_A;
    else nxt = cur;
  end
endmodule

// File: rtl/resp_fsm_out.sv
module resp_fsm_out
  import resp_fsm_pkg::*;
(
  input  rstate_t cur,
  input  logic    adv,
  input  logic    bit_in,
  output logic    z
);
  logic armed;

  always_comb begin
    case (cur)
      ST_D, ST_E: armed = 1'b1;
      default:    armed = 1'b0;
    endcase
  end

  assign z = adv & bit_in & armed;
endmodule

// File: rtl/resp_fsm_reg.sv
module resp_fsm_reg
  import resp_fsm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  rstate_t d,
  output rstate_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= ST_A;
    else q <= d;
  end
endmodule

// File: rtl/resp_fsm.sv
module resp_fsm
  import resp_fsm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_valid,
  output logic               bit_ready,
  input  logic               bit_in,
  output logic               resp_valid,
  output logic               resp_bit,
  output logic [STATE_W-1:0] state_code
);
  rstate_t cur_q;
  rstate_t nxt_d;
  logic    adv;
  logic    z;

  assign adv = bit_valid & ~rst;

  resp_fsm_next u_next (.cur(cur_q), .adv(adv), .bit_in(bit_in), .nxt(nxt_d));
  resp_fsm_out  u_out  (.cur(cur_q), .adv(adv), .bit_in(bit_in), .z(z));
  resp_fsm_reg  u_reg  (.clk(clk), .rst(rst), .d(nxt_d), .q(cur_q));

  assign bit_ready  = 1'b1;
  assign resp_valid = bit_valid;
  assign resp_bit   = z;
  assign state_code = cur_q;

  // R1
  reset_to_a_chk: assert property (@(posedge clk) rst |=> (cur_q == ST_A));

  // R5
  d_hold_on_one_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && cur_q == ST_D) |=> (cur_q == ST_D));

  // R6
  e_zero_to_a_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in && cur_q == ST_E) |=> (cur_q == ST_A));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(cur_q));

  // R5 R6 response only from armed states on a one
  resp_armed_chk: assert property (@(posedge clk) disable iff (rst)
    resp_bit |-> (bit_valid && bit_in && (cur_q == ST_D || cur_q == ST_E)));

  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cur_q <= ST_E));
endmodule

// File: tb/resp_fsm_test.sv
`timescale 1ns/100ps
module resp_fsm_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic bit_ready, resp_valid, resp_bit;
  logic [2:0] state_code;

  int checks = 0;
  int failures = 0;
  int model = 0;
  int nxt_tab [5][2];
  int out_tab [5][2];
  string tags [5];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  resp_fsm uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_in(bit_in), .resp_valid(resp_valid), .resp_bit(resp_bit),
    .state_code(state_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b);
    @(negedge clk);
    bit_valid = v;
    bit_in = b;
    #1;
    check("R10", int'(state_code <= 3'd4), 1);
    check(v ? tags[model] : "R7", int'(state_code), model);
    check("R8", int'(resp_valid), int'(v));
    check("R8", int'(bit_ready), 1);
    check(v ? tags[model] : "R7", int'(resp_bit), v ? out_tab[model][b] : 0);
    @(posedge clk);
    if (v) model = nxt_tab[model][b];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b1;
    bit_in = 1'b1;
    #1;
    check("R1", int'(resp_bit), 0);
    @(negedge clk);
    #1;
    check("R1", int'(state_code), 0);
    rst = 1'b0;
    bit_valid = 1'b0;
    model = 0;
  endtask

  initial begin
    tags = '{"R2", "R3", "R4", "R5", "R6"};
    nxt_tab = '{'{0, 1}, '{2, 3}, '{0, 3}, '{4, 3}, '{0, 3}};
    out_tab = '{'{0, 0}, '{0, 0}, '{0, 0}, '{0, 1}, '{0, 1}};
  end

  initial begin
    int trace_in  [11] = '{0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 0};
    int trace_st  [12] = '{0, 0, 1, 2, 3, 4, 3, 3, 4, 3, 4, 0};
    int trace_out [11] = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0};
    do_reset();
    // R9 sample trace
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      #1;
      check("R9", int'(state_code), trace_st[i]);
      bit_valid = 1'b1;
      bit_in = trace_in[i][0];
      #1;
      check("R9", int'(resp_bit), trace_out[i]);
      @(posedge clk);
      model = nxt_tab[model][trace_in[i]];
    end
    @(negedge clk);
    #1;
    check("R9", int'(state_code), trace_st[11]);
    bit_valid = 1'b0;
    // remaining edges: b on 1, c on 0
    step(1, 1); step(1, 1); step(1, 1); step(1, 0); step(1, 0);
    step(1, 1); step(1, 0); step(1, 0); step(1, 0);
    // R7 idle cycles in the armed state D
    step(1, 1); step(1, 1);
    step(0, 1); step(0, 0); step(0, 1);
    step(1, 1); step(1, 0);
    step(0, 1); step(1, 1);
    // R1 reset from a non-A state
    step(1, 0);
    do_reset();
    step(1, 1); step(1, 0); step(1, 1); step(1, 1);
    for (int k = 0; k < 40; k++) step(1'b1, logic'(((k * 7) % 5) < 2));
    step(0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule